// File: doc/BRIEF.md
# I/O Instruction Reply Tracker

This block follows a single I/O instruction from the moment the processor issues it until the addressed channel answers, or until it is clear that no answer will come. The processor presents one of four instruction kinds together with a channel number. The block records which kind is outstanding and which channel was addressed. When the answer arrives, it records the condition code that came back and whether a check condition was reported.

A deadline counter measures the wait against a fixed budget of 74 microseconds, expressed in clock cycles as `74 * CYCLES_PER_US`. If the budget runs out, a timeout flag is raised while the instruction stays outstanding. If a second budget also runs out with no answer, a timeout-check flag is raised and the instruction is abandoned.

Separately, an interrupt latch collects requests from channels whose bit is set in an 8-bit mask register. The instruction-fetch logic samples this latch and clears it with an acknowledge.

Top module: `io_reply_tracker`

## Requirements
- R1: `req_op` encodes the instruction kind as 0 = start I/O, 1 = test I/O, 2 = halt I/O, 3 = test channel. An accepted request sets only bit `req_op` of `pend_kind` on the next edge. That bit stays set until the channel answers or the instruction is abandoned, so at most one bit is ever set.
- R2: On an accepted request, `cur_chan` takes the value of `req_chan` on the same edge and holds it until the next accepted request.
- R3: `cc_out` loads `chan_cc` only on an edge where `chan_reply` is high while an instruction is outstanding. An accepted request clears it to 0, and otherwise it holds.
- R4: `chan_reply` while an instruction is outstanding sets `reply_flag` and clears `pend_kind` on the same edge. `chan_reply` while nothing is outstanding changes nothing.
- R5: With LIMIT = 74*CYCLES_PER_US, `timeout_flag` becomes visible after the LIMIT-th edge following the accepting edge if no reply was taken on any of those edges. A reply on that edge itself wins and leaves the flag clear. The instruction stays outstanding after a timeout.
- R6: If no reply has arrived by the 2*LIMIT-th edge after acceptance, `tochk_flag` sets on that edge and `pend_kind` clears. `tochk_flag` is never set without `timeout_flag`.
- R7: A request is accepted only when nothing is outstanding. An accepted request clears `reply_flag`, `timeout_flag`, `tochk_flag` and `foul_flag`. A request made while an instruction is outstanding is ignored.
- R8: `mask_wr` loads `mask_data` into the mask register; bit i enables channel i. `irq_latch` sets on any edge where `chan_irq & mask` is non-zero, using the mask value held before that edge.
- R9: `irq_ack` clears `irq_latch`, except on an edge where the set condition of R8 also holds; in that case the latch stays set.
- R10: `foul_flag` sets when `chan_check` accompanies an accepted reply while start I/O (bit 0) is outstanding. A check with any other kind leaves it clear.
- R11: A synchronous active-high `rst` clears all flags, `pend_kind`, `cur_chan`, `cc_out`, the mask and the deadline counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction issue strobe |
| req_op | input | 2 | Instruction kind (R1 encoding) |
| req_chan | input | 3 | Addressed channel number |
| chan_reply | input | 1 | Channel answer strobe |
| chan_cc | input | 2 | Condition code returned with the answer |
| chan_check | input | 1 | Check condition reported with the answer |
| chan_irq | input | 8 | Per-channel interrupt requests |
| mask_wr | input | 1 | Mask register write strobe |
| mask_data | input | 8 | New mask value |
| irq_ack | input | 1 | Interrupt acknowledge from fetch logic |
| pend_kind | output | 4 | One-hot outstanding instruction kind |
| cur_chan | output | 3 | Held channel number |
| cc_out | output | 2 | Held condition code |
| reply_flag | output | 1 | Answer received |
| timeout_flag | output | 1 | First deadline passed |
| tochk_flag | output | 1 | Second deadline passed, instruction abandoned |
| foul_flag | output | 1 | Check reported on start I/O |
| irq_latch | output | 1 | Masked channel interrupt pending |

## Verification
The timeout-check flag is the hardest state to reach: it needs the channel to stay silent for 296 consecutive cycles while an instruction is outstanding. Random traffic with ordinary reply odds almost never produces that. The stimulus therefore alternates random segments in which replies are disabled outright with segments where replies are frequent. Directed cases place a reply exactly on the first deadline edge and on the edge just before the second deadline.

// File: rtl/io_trk_pkg.sv
package io_trk_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_TEST  = 2'd1,
    OP_HALT  = 2'd2,
    OP_TCHAN = 2'd3
  } io_op_e;

  localparam int NUM_KINDS = 4;
endpackage

// File: rtl/io_trk_deadline.sv
module io_trk_deadline #(
  parameter int LIMIT = 148,
  localparam int CW = $clog2(2 * LIMIT)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic stop,
  output logic first_hit,
  output logic second_hit
);
  localparam logic [CW-1:0] FIRST_END  = CW'(LIMIT - 1);
  localparam logic [CW-1:0] SECOND_END = CW'(2 * LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (run && !stop && cnt != SECOND_END) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    first_hit  = run && !stop && (cnt == FIRST_END);
    second_hit = run && !stop && (cnt == SECOND_END);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= SECOND_END); // R6
endmodule

// File: rtl/io_trk_irq.sv
module io_trk_irq #(
  parameter int N_CHAN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CHAN-1:0] chan_irq,
  input  logic              mask_wr,
  input  logic [N_CHAN-1:0] mask_data,
  input  logic              irq_ack,
  output logic              irq_latch
);
  logic [N_CHAN-1:0] mask_q;
  logic [N_CHAN-1:0] masked;
  logic              any_req;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (mask_wr) mask_q <= mask_data;
  end

  for (genvar i = 0; i < N_CHAN; i++) begin : g_gate
    assign masked[i] = chan_irq[i] & mask_q[i];
  end

  assign any_req = |masked;

  always_ff @(posedge clk) begin
    if (rst) irq_latch <= 1'b0;
    else if (any_req) irq_latch <= 1'b1;
    else if (irq_ack) irq_latch <= 1'b0;
  end

  AST_IRQ_SETS: assert property (@(posedge clk) disable iff (rst)
    any_req |=> irq_latch); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !any_req) |=> !irq_latch); // R9
endmodule

// File: rtl/io_trk_status.sv
module io_trk_status
  import io_trk_pkg::*;
#(
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  io_op_e            req_op,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              chan_reply,
  input  logic [1:0]        chan_cc,
  input  logic              chan_check,
  input  logic              first_hit,
  input  logic              second_hit,
  output logic              accept,
  output logic              busy,
  output logic              took_reply,
  output logic [NUM_KINDS-1:0] pend_kind,
  output logic [CHAN_W-1:0] cur_chan,
  output logic [1:0]        cc_out,
  output logic              reply_flag,
  output logic              timeout_flag,
  output logic              tochk_flag,
  output logic              foul_flag
);
  always_comb begin
    busy       = |pend_kind;
    accept     = req_valid && !busy;
    took_reply = busy && chan_reply;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_kind    <= '0;
      cur_chan     <= '0;
      cc_out       <= '0;
      reply_flag   <= 1'b0;
      timeout_flag <= 1'b0;
      tochk_flag   <= 1'b0;
      foul_flag    <= 1'b0;
    end else if (accept) begin
      pend_kind    <= NUM_KINDS'(1) << req_op;
      cur_chan     <= req_chan;
      cc_out       <= '0;
      reply_flag   <= 1'b0;
      timeout_flag <= 1'b0;
      tochk_flag   <= 1'b0;
      foul_flag    <= 1'b0;
    end else if (took_reply) begin
      pend_kind  <= '0;
      cc_out     <= chan_cc;
      reply_flag <= 1'b1;
      foul_flag  <= chan_check && pend_kind[OP_START];
    end else begin
      if (first_hit) timeout_flag <= 1'b1;
      if (second_hit) begin
        tochk_flag <= 1'b1;
        pend_kind  <= '0;
      end
    end
  end

  AST_ONE_PENDING: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend_kind)); // R1
  AST_REPLY_ENDS: assert property (@(posedge clk) disable iff (rst)
    took_reply |=> (pend_kind == '0) && reply_flag); // R4
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!accept && !took_reply) |=> $stable(cc_out)); // R3
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> $stable(cur_chan)); // R7
  AST_CHECK_AFTER_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
    tochk_flag |-> timeout_flag); // R6
endmodule

// File: rtl/io_reply_tracker.sv
module io_reply_tracker
  import io_trk_pkg::*;
#(
  parameter int CYCLES_PER_US = 2,
  parameter int DEADLINE_US   = 74,
  parameter int N_CHAN        = 8,
  localparam int CHAN_W = $clog2(N_CHAN),
  localparam int LIMIT  = CYCLES_PER_US * DEADLINE_US
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              chan_reply,
  input  logic [1:0]        chan_cc,
  input  logic              chan_check,
  input  logic [N_CHAN-1:0] chan_irq,
  input  logic              mask_wr,
  input  logic [N_CHAN-1:0] mask_data,
  input  logic              irq_ack,
  output logic [3:0]        pend_kind,
  output logic [CHAN_W-1:0] cur_chan,
  output logic [1:0]        cc_out,
  output logic              reply_flag,
  output logic              timeout_flag,
  output logic              tochk_flag,
  output logic              foul_flag,
  output logic              irq_latch
);
  logic accept, busy, took_reply, first_hit, second_hit;

  io_trk_status #(.CHAN_W(CHAN_W)) u_status (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(io_op_e'(req_op)), .req_chan(req_chan),
    .chan_reply(chan_reply), .chan_cc(chan_cc), .chan_check(chan_check),
    .first_hit(first_hit), .second_hit(second_hit),
    .accept(accept), .busy(busy), .took_reply(took_reply),
    .pend_kind(pend_kind), .cur_chan(cur_chan), .cc_out(cc_out),
    .reply_flag(reply_flag), .timeout_flag(timeout_flag),
    .tochk_flag(tochk_flag), .foul_flag(foul_flag)
  );

  io_trk_deadline #(.LIMIT(LIMIT)) u_deadline (
    .clk(clk), .rst(rst),
    .start(accept), .run(busy), .stop(chan_reply),
    .first_hit(first_hit), .second_hit(second_hit)
  );

  io_trk_irq #(.N_CHAN(N_CHAN)) u_irq (
    .clk(clk), .rst(rst),
    .chan_irq(chan_irq), .mask_wr(mask_wr), .mask_data(mask_data),
    .irq_ack(irq_ack), .irq_latch(irq_latch)
  );

  AST_TIMEOUT_KEEPS_PENDING: assert property (@(posedge clk) disable iff (rst)
    (first_hit && !second_hit) |=> timeout_flag && (pend_kind != '0)); // R5
endmodule

// File: tb/test_io_reply_tracker.sv
`timescale 1ns/1ps
module test_io_reply_tracker;
  localparam int CPU   = 2;
  localparam int LIMIT = 74 * CPU;

  logic clk = 1'b0;
  logic rst;
  logic req_valid, chan_reply, chan_check, mask_wr, irq_ack;
  logic [1:0] req_op, chan_cc;
  logic [2:0] req_chan;
  logic [7:0] chan_irq, mask_data;
  logic [3:0] pend_kind;
  logic [2:0] cur_chan;
  logic [1:0] cc_out;
  logic reply_flag, timeout_flag, tochk_flag, foul_flag, irq_latch;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_pend;
  logic [2:0] m_chan;
  logic [1:0] m_cc;
  logic m_reply, m_to, m_tochk, m_foul, m_irq;
  logic [7:0] m_mask;
  int m_cnt;

  always #2.5 clk = ~clk;

  io_reply_tracker #(.CYCLES_PER_US(CPU)) i_io_reply_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_chan(req_chan), .chan_reply(chan_reply), .chan_cc(chan_cc),
    .chan_check(chan_check), .chan_irq(chan_irq), .mask_wr(mask_wr),
    .mask_data(mask_data), .irq_ack(irq_ack), .pend_kind(pend_kind),
    .cur_chan(cur_chan), .cc_out(cc_out), .reply_flag(reply_flag),
    .timeout_flag(timeout_flag), .tochk_flag(tochk_flag),
    .foul_flag(foul_flag), .irq_latch(irq_latch)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] kind_bit(input logic [1:0] op);
    return 4'b0001 << op;
  endfunction

  task automatic model_step();
    if (rst) begin
      m_pend = 0; m_chan = 0; m_cc = 0; m_reply = 0; m_to = 0;
      m_tochk = 0; m_foul = 0; m_irq = 0; m_mask = 0; m_cnt = 0;
    end else begin
      if ((chan_irq & m_mask) != 0) m_irq = 1;
      else if (irq_ack) m_irq = 0;
      if (mask_wr) m_mask = mask_data;
      if (m_pend != 0) begin
        if (chan_reply) begin
          m_foul = chan_check && m_pend[0];
          m_pend = 0; m_reply = 1; m_cc = chan_cc;
        end else begin
          if (m_cnt == LIMIT - 1) m_to = 1;
          if (m_cnt == 2 * LIMIT - 1) begin m_tochk = 1; m_pend = 0; end
          m_cnt++;
        end
      end else if (req_valid) begin
        m_pend = kind_bit(req_op); m_chan = req_chan; m_cc = 0;
        m_reply = 0; m_to = 0; m_tochk = 0; m_foul = 0; m_cnt = 0;
      end
    end
  endtask

  task automatic compare_all();
    chk("R1 pend_kind", pend_kind, m_pend);
    chk("R2 cur_chan", cur_chan, m_chan);
    chk("R3 cc_out", cc_out, m_cc);
    chk("R4 reply_flag", reply_flag, m_reply);
    chk("R5 timeout_flag", timeout_flag, m_to);
    chk("R6 tochk_flag", tochk_flag, m_tochk);
    chk("R10 foul_flag", foul_flag, m_foul);
    chk("R8 irq_latch", irq_latch, m_irq);
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_op = 0; req_chan = 0; chan_reply = 0; chan_cc = 0;
    chan_check = 0; chan_irq = 0; mask_wr = 0; mask_data = 0; irq_ack = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    compare_all();
    @(negedge clk);
    idle_inputs();
    rst = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] ch);
    req_valid = 1; req_op = op; req_chan = ch;
    tick();
  endtask

  task automatic answer(input logic [1:0] cc, input logic chk_in);
    chan_reply = 1; chan_cc = cc; chan_check = chk_in;
    tick();
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(5ns * 190000);
    errors++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd4711);
    idle_inputs();
    rst = 1;
    @(negedge clk);
    idle_inputs(); rst = 1;
    tick();
    // R11: reset state
    chk("R11 reset pend", pend_kind, 4'd0);
    chk("R11 reset flags", {reply_flag, timeout_flag, tochk_flag, foul_flag, irq_latch}, 5'd0);

    // R1/R2/R3/R4: halt I/O on channel 5, answered with cc 2
    issue(2'd2, 3'd5);
    chk("R1 halt bit", pend_kind, 4'b0100);
    chk("R2 channel", cur_chan, 3'd5);
    wait_cycles(3);
    answer(2'd2, 1'b0);
    chk("R4 reply set", reply_flag, 1'b1);
    chk("R3 cc latched", cc_out, 2'd2);
    // R4: reply with nothing outstanding has no effect
    answer(2'd1, 1'b1);
    chk("R4 idle reply ignored cc", cc_out, 2'd2);
    chk("R10 idle check no foul", foul_flag, 1'b0);

    // R10: check on start I/O sets foul, on test I/O it does not
    issue(2'd0, 3'd1);
    answer(2'd3, 1'b1);
    chk("R10 foul on start", foul_flag, 1'b1);
    issue(2'd1, 3'd2);
    chk("R7 new request clears foul", foul_flag, 1'b0);
    answer(2'd0, 1'b1);
    chk("R10 no foul on test", foul_flag, 1'b0);

    // R7: request while pending ignored
    issue(2'd3, 3'd7);
    issue(2'd0, 3'd4);
    chk("R7 busy request ignored kind", pend_kind, 4'b1000);
    chk("R7 busy request ignored chan", cur_chan, 3'd7);
    answer(2'd1, 1'b0);

    // R5: reply exactly on the first deadline edge wins
    issue(2'd1, 3'd3);
    wait_cycles(LIMIT - 1);
    answer(2'd3, 1'b0);
    chk("R5 reply on deadline edge", timeout_flag, 1'b0);

    // R5/R6: silence through both deadlines
    issue(2'd0, 3'd6);
    wait_cycles(LIMIT - 1);
    chk("R5 not yet", timeout_flag, 1'b0);
    tick();
    chk("R5 timeout set", timeout_flag, 1'b1);
    chk("R5 still pending", pend_kind, 4'b0001);
    wait_cycles(LIMIT - 1);
    chk("R6 not yet", tochk_flag, 1'b0);
    tick();
    chk("R6 tochk set", tochk_flag, 1'b1);
    chk("R6 abandoned", pend_kind, 4'd0);
    issue(2'd2, 3'd0);
    chk("R7 clears timeout", {timeout_flag, tochk_flag, reply_flag}, 3'd0);
    wait_cycles(2 * LIMIT - 2);
    answer(2'd1, 1'b0);
    chk("R6 reply just before second deadline", {tochk_flag, reply_flag}, 2'b01);

    // R8/R9: interrupt latch and mask
    chan_irq = 8'h10; tick();
    chk("R8 masked channel ignored", irq_latch, 1'b0);
    mask_wr = 1; mask_data = 8'h10; chan_irq = 8'h10; tick();
    chk("R8 old mask used on write edge", irq_latch, 1'b0);
    chan_irq = 8'h10; tick();
    chk("R8 unmasked sets latch", irq_latch, 1'b1);
    irq_ack = 1; chan_irq = 8'h10; tick();
    chk("R9 set wins over ack", irq_latch, 1'b1);
    irq_ack = 1; tick();
    chk("R9 ack clears", irq_latch, 1'b0);

    // Random segments: alternate silent and chatty channel behaviour
    for (int seg = 0; seg < 40; seg++) begin
      int reply_pct;
      reply_pct = (seg % 3 == 0) ? 0 : 15;
      for (int c = 0; c < 400; c++) begin
        req_valid  = ($urandom_range(0, 99) < 30);
        req_op     = 2'($urandom_range(0, 3));
        req_chan   = 3'($urandom_range(0, 7));
        chan_reply = ($urandom_range(0, 99) < reply_pct);
        chan_cc    = 2'($urandom_range(0, 3));
        chan_check = ($urandom_range(0, 99) < 40);
        chan_irq   = ($urandom_range(0, 99) < 10) ? 8'($urandom) : 8'h00;
        mask_wr    = ($urandom_range(0, 99) < 3);
        mask_data  = 8'($urandom);
        irq_ack    = ($urandom_range(0, 99) < 20);
        rst        = ($urandom_range(0, 999) == 0);
        tick();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule